// File: doc/BRIEF.md
# Multiplex Section Parity Error Monitor

This block watches a received byte stream and checks the line-level interleaved parity carried in each frame. Every byte outside the regenerator overhead rows is folded into one of several 8-bit even-parity lanes. At the next frame boundary those lane values become the reference that the parity bytes of the following frame must match. Every bit that differs counts as one error.

The total of one frame's errors is used in three ways. It becomes a remote-error value for the outgoing M1 byte, capped at what the interface rate can carry. It builds up in a saturating counter that the host reads, and the read clears it. It also feeds two independent window alarms, one for excessive errors and one for signal degrade, each with its own window length and its own set and clear thresholds. The remote-error value and both alarm states also leave the block as a short serial word with a sync marker. Input markers give the frame start, regenerator overhead bytes and parity bytes. Descrambling and host bus decoding belong elsewhere.

Top module: `b2_bip_monitor`

## Requirements
- R1: A byte with `in_valid` high and `rsoh` low is XORed into lane (p mod N_B2). Here p counts accepted bytes from 0 at the byte carrying `frame_start`. Lanes restart at each frame start. The j-th byte (j from 0) marked `b2_mark` in a frame is compared with lane j of the previous frame. Each differing bit adds one to that frame's error total. Marked bytes past the N_B2-th, and a mark on the frame-start byte, are not compared.
- R2: A frame's total is reported only if a full previous frame gave it a reference. The first two frames after reset therefore produce no report for the first.
- R3: When the `frame_start` byte of the next frame is accepted at clock edge k, `rei_valid` is high for exactly the one cycle after edge k+1.
- R4: With `rei_valid`, `rei_value` gives the frame total capped at REI_MAX. If `rei_en` was low at that edge, `rei_value` is 0. It holds between reports.
- R5: The host counter adds each reported frame total and sticks at 2^CNT_W-1 instead of wrapping.
- R6: A one-cycle `rd_req` makes `rd_valid` high in the next cycle. `rd_data` then holds the count from before that edge. The count restarts from only that edge's frame total, if any.
- R7: `exc_alarm` is evaluated after every `exc_win` reported frames (0 acts as 1). It is set if the window sum is greater than `exc_set`, cleared if the sum is less than `exc_clr`, and otherwise left as it was. It changes at the same edge as `rei_valid`.
- R8: `deg_alarm` follows the R7 rule with `deg_win`, `deg_set` and `deg_clr`, independently of the other alarm.
- R9: One cycle after `rei_valid`, `ser_data` sends {rei_value, exc_alarm, deg_alarm} most significant bit first, one bit per cycle. `ser_sync` is high only with the first bit, and `ser_data` is 0 when idle.
- R10: Cycles with `in_valid` low change no lane, position, parity index or report, whatever the markers and data show.
- R11: In reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Byte qualifier |
| in_byte | input | 8 | Received byte |
| frame_start | input | 1 | First byte of a frame |
| rsoh | input | 1 | Byte belongs to regenerator overhead rows |
| b2_mark | input | 1 | Byte is a received parity byte |
| rei_en | input | 1 | Enable remote-error value |
| rei_valid | output | 1 | New remote-error value pulse |
| rei_value | output | REI_W | Capped frame error total |
| rd_req | input | 1 | Host read-and-clear request |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | CNT_W | Latched error count |
| exc_win | input | WIN_W | Excessive-error window, frames |
| exc_set | input | SUM_W | Excessive-error set threshold |
| exc_clr | input | SUM_W | Excessive-error clear threshold |
| deg_win | input | WIN_W | Degrade window, frames |
| deg_set | input | SUM_W | Degrade set threshold |
| deg_clr | input | SUM_W | Degrade clear threshold |
| exc_alarm | output | 1 | Excessive-error alarm |
| deg_alarm | output | 1 | Signal-degrade alarm |
| ser_data | output | 1 | Serial alarm word bit |
| ser_sync | output | 1 | First-bit marker of serial word |

## Verification
A frame's result is due two edges after its successor's start byte is taken. One edge registers the parity stage's frame report. The next edge updates `rei_valid`, `rei_value`, the counter and both alarms together, and the serial word begins one edge later. The bench model works through the same edge order stage by stage: serial from the previous report, then report effects, then byte intake. It updates at each rising edge, and outputs are compared with it at every falling edge. That way every result is checked in exactly the cycle it is due, and any early or late change shows up as a mismatch.

// File: rtl/b2_bip_pkg.sv
package b2_bip_pkg;

   localparam int NUM_ALARMS = 2;

   typedef enum int {
      ALM_EXC = 0,
      ALM_DEG = 1
   } alarm_idx_e;

   // number of set bits in one byte
   function automatic logic [3:0] ones8(input logic [7:0] v);
      logic [3:0] c;
      c = '0;
      for (int i = 0; i < 8; i++) c = c + {3'b000, v[i]};
      return c;
   endfunction

endpackage

// File: rtl/b2_lane_parity.sv
module b2_lane_parity
   import b2_bip_pkg::*;
#(
   parameter int N_B2 = 4,
   parameter int FE_W = $clog2(8 * N_B2 + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [7:0]      in_byte,
   input  logic            frame_start,
   input  logic            rsoh,
   input  logic            b2_mark,
   output logic            frame_done,
   output logic [FE_W-1:0] frame_errs
);

   localparam int LW = (N_B2 > 1) ? $clog2(N_B2) : 1;
   localparam int IW = $clog2(N_B2 + 1);

   generate
      if (N_B2 < 2) begin : g_bad_lanes
         $error("b2_lane_parity: N_B2 must be at least 2");
      end
      if (FE_W < $clog2(8 * N_B2 + 1)) begin : g_bad_few
         $error("b2_lane_parity: FE_W too small for N_B2");
      end
   endgenerate

   logic [LW-1:0]   pos_q;
   logic [LW-1:0]   lane_now;
   logic [IW-1:0]   idx_q;
   logic            seen_q;
   logic            ref_ok_q;
   logic [FE_W-1:0] ferr_q;
   logic [FE_W-1:0] cmp_bits;
   logic [7:0]      ref_w [N_B2];
   logic [7:0]      ref_sel;
   logic            b2_take;
   logic            start_take;

   assign start_take = in_valid && frame_start;
   assign lane_now   = frame_start ? '0 : pos_q;
   assign b2_take    = in_valid && !frame_start && b2_mark;

   always_comb begin
      ref_sel = '0;
      for (int i = 0; i < N_B2; i++) begin
         if (idx_q == IW'(i)) ref_sel = ref_w[i];
      end
   end

   assign cmp_bits = (b2_take && ref_ok_q && (idx_q < IW'(N_B2)))
                     ? FE_W'(ones8(in_byte ^ ref_sel)) : '0;

   // one parity lane per interleave column
   generate
      for (genvar g = 0; g < N_B2; g++) begin : g_lane
         logic [7:0] acc_q;
         logic [7:0] ref_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
               ref_q <= '0;
            end else if (in_valid) begin
               if (frame_start) begin
                  acc_q <= (g == 0 && !rsoh) ? in_byte : 8'h00;
                  if (seen_q) ref_q <= acc_q;
               end else if (!rsoh && lane_now == LW'(g)) begin
                  acc_q <= acc_q ^ in_byte;
               end
            end
         end
         assign ref_w[g] = ref_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         idx_q    <= '0;
         seen_q   <= 1'b0;
         ref_ok_q <= 1'b0;
         ferr_q   <= '0;
      end else if (in_valid) begin
         pos_q <= (lane_now == LW'(N_B2 - 1)) ? '0 : lane_now + LW'(1);
         if (frame_start) begin
            idx_q    <= '0;
            ferr_q   <= '0;
            seen_q   <= 1'b1;
            ref_ok_q <= seen_q;
         end else begin
            ferr_q <= ferr_q + cmp_bits;
            if (b2_mark && idx_q < IW'(N_B2)) idx_q <= idx_q + IW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_done <= 1'b0;
         frame_errs <= '0;
      end else begin
         frame_done <= start_take && ref_ok_q;
         if (start_take) frame_errs <= ferr_q;
      end
   end

endmodule

// File: rtl/b2_err_counter.sv
module b2_err_counter #(
   parameter int CNT_W = 16,
   parameter int IN_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_valid,
   input  logic [IN_W-1:0]  inc,
   input  logic             rd_req,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_data
);

   generate
      if (IN_W > CNT_W) begin : g_bad_w
         $error("b2_err_counter: IN_W must not exceed CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] add;
   logic [CNT_W:0]   raw;
   logic [CNT_W-1:0] next_cnt;

   assign base     = rd_req ? '0 : cnt_q;
   assign add      = inc_valid ? CNT_W'(inc) : '0;
   assign raw      = {1'b0, base} + {1'b0, add};
   assign next_cnt = raw[CNT_W] ? '1 : raw[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         cnt_q    <= next_cnt;
         rd_valid <= rd_req;
         if (rd_req) rd_data <= cnt_q;
      end
   end

endmodule

// File: rtl/b2_window_alarm.sv
module b2_window_alarm #(
   parameter int WIN_W = 8,
   parameter int SUM_W = 12,
   parameter int IN_W  = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_done,
   input  logic [IN_W-1:0]  frame_errs,
   input  logic [WIN_W-1:0] win_len,
   input  logic [SUM_W-1:0] set_th,
   input  logic [SUM_W-1:0] clr_th,
   output logic             alarm
);

   generate
      if (IN_W > SUM_W) begin : g_bad_w
         $error("b2_window_alarm: IN_W must not exceed SUM_W");
      end
   endgenerate

   logic [WIN_W-1:0] fcnt_q;
   logic [WIN_W-1:0] len_eff;
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W:0]   raw;
   logic [SUM_W-1:0] tot;
   logic             last;

   assign len_eff = (win_len == '0) ? WIN_W'(1) : win_len;
   assign raw     = {1'b0, sum_q} + (SUM_W + 1)'(frame_errs);
   assign tot     = raw[SUM_W] ? '1 : raw[SUM_W-1:0];
   assign last    = ({1'b0, fcnt_q} + (WIN_W + 1)'(1)) >= {1'b0, len_eff};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fcnt_q <= '0;
         sum_q  <= '0;
         alarm  <= 1'b0;
      end else if (frame_done) begin
         if (last) begin
            fcnt_q <= '0;
            sum_q  <= '0;
            if (tot > set_th)      alarm <= 1'b1;
            else if (tot < clr_th) alarm <= 1'b0;
         end else begin
            fcnt_q <= fcnt_q + WIN_W'(1);
            sum_q  <= tot;
         end
      end
   end

endmodule

// File: rtl/b2_alarm_serial.sv
module b2_alarm_serial #(
   parameter int REI_W     = 5,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REI_W-1:0] rei,
   input  logic             exc,
   input  logic             deg,
   output logic             ser_data,
   output logic             ser_sync
);

   localparam int SW = REI_W + 2;
   localparam int LCW = $clog2(SW);

   logic [SW-1:0]  word;
   logic [SW-1:0]  word_ord;
   logic [SW-1:0]  sh_q;
   logic [LCW-1:0] left_q;

   assign word = {rei, exc, deg};

   generate
      if (MSB_FIRST) begin : g_msb
         assign word_ord = word;
      end else begin : g_lsb
         for (genvar b = 0; b < SW; b++) begin : g_rev
            assign word_ord[b] = word[SW-1-b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q     <= '0;
         left_q   <= '0;
         ser_data <= 1'b0;
         ser_sync <= 1'b0;
      end else if (load) begin
         sh_q     <= word_ord;
         left_q   <= LCW'(SW - 1);
         ser_data <= word_ord[SW-1];
         ser_sync <= 1'b1;
      end else if (left_q != '0) begin
         sh_q     <= sh_q << 1;
         left_q   <= left_q - LCW'(1);
         ser_data <= sh_q[SW-2];
         ser_sync <= 1'b0;
      end else begin
         ser_data <= 1'b0;
         ser_sync <= 1'b0;
      end
   end

endmodule

// File: rtl/b2_bip_monitor.sv
module b2_bip_monitor
   import b2_bip_pkg::*;
#(
   parameter int N_B2    = 4,
   parameter int REI_MAX = 20,
   parameter int CNT_W   = 16,
   parameter int WIN_W   = 8,
   parameter int SUM_W   = 12,
   localparam int REI_W  = $clog2(REI_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_byte,
   input  logic             frame_start,
   input  logic             rsoh,
   input  logic             b2_mark,
   input  logic             rei_en,
   output logic             rei_valid,
   output logic [REI_W-1:0] rei_value,
   input  logic             rd_req,
   output logic             rd_valid,
   output logic [CNT_W-1:0] rd_data,
   input  logic [WIN_W-1:0] exc_win,
   input  logic [SUM_W-1:0] exc_set,
   input  logic [SUM_W-1:0] exc_clr,
   input  logic [WIN_W-1:0] deg_win,
   input  logic [SUM_W-1:0] deg_set,
   input  logic [SUM_W-1:0] deg_clr,
   output logic             exc_alarm,
   output logic             deg_alarm,
   output logic             ser_data,
   output logic             ser_sync
);

   localparam int FE_W    = $clog2(8 * N_B2 + 1);
   localparam int ERR_MAX = 8 * N_B2;

   generate
      if (REI_MAX < 1) begin : g_bad_rei
         $error("b2_bip_monitor: REI_MAX must be positive");
      end
   endgenerate

   logic            frm_done;
   logic [FE_W-1:0] frm_errs;
   logic [REI_W-1:0] rei_capped;

   b2_lane_parity #(.N_B2(N_B2), .FE_W(FE_W)) u_par (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .in_byte     (in_byte),
      .frame_start (frame_start),
      .rsoh        (rsoh),
      .b2_mark     (b2_mark),
      .frame_done  (frm_done),
      .frame_errs  (frm_errs)
   );

   // cap only when the frame total can exceed the M1 range
   generate
      if (ERR_MAX > REI_MAX) begin : g_cap
         assign rei_capped = (32'(frm_errs) > REI_MAX) ? REI_W'(REI_MAX)
                                                       : REI_W'(frm_errs);
      end else begin : g_nocap
         assign rei_capped = REI_W'(frm_errs);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rei_valid <= 1'b0;
         rei_value <= '0;
      end else begin
         rei_valid <= frm_done;
         if (frm_done) rei_value <= rei_en ? rei_capped : '0;
      end
   end

   b2_err_counter #(.CNT_W(CNT_W), .IN_W(FE_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_valid (frm_done),
      .inc       (frm_errs),
      .rd_req    (rd_req),
      .rd_valid  (rd_valid),
      .rd_data   (rd_data)
   );

   logic [WIN_W-1:0] win_a [NUM_ALARMS];
   logic [SUM_W-1:0] set_a [NUM_ALARMS];
   logic [SUM_W-1:0] clr_a [NUM_ALARMS];
   logic             alm_a [NUM_ALARMS];

   assign win_a[ALM_EXC] = exc_win;
   assign set_a[ALM_EXC] = exc_set;
   assign clr_a[ALM_EXC] = exc_clr;
   assign win_a[ALM_DEG] = deg_win;
   assign set_a[ALM_DEG] = deg_set;
   assign clr_a[ALM_DEG] = deg_clr;

   generate
      for (genvar a = 0; a < NUM_ALARMS; a++) begin : g_alarm
         b2_window_alarm #(.WIN_W(WIN_W), .SUM_W(SUM_W), .IN_W(FE_W)) u_win (
            .clk        (clk),
            .rst_n      (rst_n),
            .frame_done (frm_done),
            .frame_errs (frm_errs),
            .win_len    (win_a[a]),
            .set_th     (set_a[a]),
            .clr_th     (clr_a[a]),
            .alarm      (alm_a[a])
         );
      end
   endgenerate

   assign exc_alarm = alm_a[ALM_EXC];
   assign deg_alarm = alm_a[ALM_DEG];

   b2_alarm_serial #(.REI_W(REI_W), .MSB_FIRST(1'b1)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (rei_valid),
      .rei      (rei_value),
      .exc      (exc_alarm),
      .deg      (deg_alarm),
      .ser_data (ser_data),
      .ser_sync (ser_sync)
   );

endmodule

// File: rtl/b2_bip_monitor_chk.sv
module b2_bip_monitor_chk #(
   parameter int REI_W   = 5,
   parameter int REI_MAX = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rei_en,
   input logic             rei_valid,
   input logic [REI_W-1:0] rei_value,
   input logic             frm_done,
   input logic             rd_req,
   input logic             rd_valid,
   input logic             exc_alarm,
   input logic             deg_alarm,
   input logic             ser_sync
);

   // R3: a report follows a frame completion from the parity stage
   a_r3_rei_after_frame: assert property (@(posedge clk) disable iff (!rst_n)
      rei_valid |-> $past(frm_done));

   // R4: value never above the M1 range
   a_r4_rei_cap: assert property (@(posedge clk) disable iff (!rst_n)
      rei_valid |-> (32'(rei_value) <= REI_MAX));

   // R4: disabled insertion gives zero
   a_r4_rei_off: assert property (@(posedge clk) disable iff (!rst_n)
      (rei_valid && !$past(rei_en)) |-> (rei_value == '0));

   // R6: read acknowledged next cycle
   a_r6_rd_ack: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);

   // R7: excessive alarm moves only on a frame report
   a_r7_exc_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_alarm != $past(exc_alarm)) |-> $past(frm_done));

   // R8: degrade alarm moves only on a frame report
   a_r8_deg_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (deg_alarm != $past(deg_alarm)) |-> $past(frm_done));

   // R9: serial word starts right after a report
   a_r9_sync: assert property (@(posedge clk) disable iff (!rst_n)
      rei_valid |=> ser_sync);

endmodule

bind b2_bip_monitor b2_bip_monitor_chk #(.REI_W(REI_W), .REI_MAX(REI_MAX)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rei_en    (rei_en),
   .rei_valid (rei_valid),
   .rei_value (rei_value),
   .frm_done  (frm_done),
   .rd_req    (rd_req),
   .rd_valid  (rd_valid),
   .exc_alarm (exc_alarm),
   .deg_alarm (deg_alarm),
   .ser_sync  (ser_sync)
);

// File: tb/b2_bip_monitor_tb.sv
`timescale 1ns/1ps
module b2_bip_monitor_tb;

   localparam int N     = 4;
   localparam int RMAX  = 20;
   localparam int CW    = 6;
   localparam int WW    = 8;
   localparam int SW    = 12;
   localparam int RW    = 5;
   localparam int FLEN  = 24;
   localparam int CMAX  = (1 << CW) - 1;
   localparam int SMAX  = (1 << SW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [7:0]    in_byte = '0;
   logic          frame_start = 1'b0;
   logic          rsoh = 1'b0;
   logic          b2_mark = 1'b0;
   logic          rei_en = 1'b1;
   logic          rei_valid;
   logic [RW-1:0] rei_value;
   logic          rd_req = 1'b0;
   logic          rd_valid;
   logic [CW-1:0] rd_data;
   logic [WW-1:0] exc_win = 8'd2;
   logic [SW-1:0] exc_set = 12'd20;
   logic [SW-1:0] exc_clr = 12'd5;
   logic [WW-1:0] deg_win = 8'd3;
   logic [SW-1:0] deg_set = 12'd6;
   logic [SW-1:0] deg_clr = 12'd2;
   logic          exc_alarm;
   logic          deg_alarm;
   logic          ser_data;
   logic          ser_sync;

   always #5 clk = ~clk;

   b2_bip_monitor #(.N_B2(N), .REI_MAX(RMAX), .CNT_W(CW), .WIN_W(WW), .SUM_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
      .frame_start(frame_start), .rsoh(rsoh), .b2_mark(b2_mark), .rei_en(rei_en),
      .rei_valid(rei_valid), .rei_value(rei_value), .rd_req(rd_req),
      .rd_valid(rd_valid), .rd_data(rd_data), .exc_win(exc_win), .exc_set(exc_set),
      .exc_clr(exc_clr), .deg_win(deg_win), .deg_set(deg_set), .deg_clr(deg_clr),
      .exc_alarm(exc_alarm), .deg_alarm(deg_alarm), .ser_data(ser_data),
      .ser_sync(ser_sync)
   );

   int n_chk = 0;
   int n_err = 0;
   bit cmp_on = 0;

   function automatic void check(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endfunction

   // behavioural reference model
   int m_acc [N];
   int m_ref [N];
   bit m_seen, m_refok;
   int m_pos, m_idx, m_ferr;
   bit pf_v;
   int pf_e;
   int exp_rei_v, exp_rei, exp_rd_v, exp_rd, m_cnt;
   int m_sum [2];
   int m_fc [2];
   int exp_al [2];
   int exp_sd, exp_ss;
   bit sq [$];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_acc[i] = 0; m_ref[i] = 0; end
         m_seen = 0; m_refok = 0; m_pos = 0; m_idx = 0; m_ferr = 0;
         pf_v = 0; pf_e = 0;
         exp_rei_v = 0; exp_rei = 0; exp_rd_v = 0; exp_rd = 0; m_cnt = 0;
         for (int a = 0; a < 2; a++) begin m_sum[a] = 0; m_fc[a] = 0; exp_al[a] = 0; end
         exp_sd = 0; exp_ss = 0; sq.delete();
      end else begin
         // serial stage, driven by the previous report
         if (exp_rei_v != 0) begin
            sq.delete();
            for (int b = RW - 1; b >= 0; b--) sq.push_back(exp_rei[b]);
            sq.push_back(exp_al[0][0]);
            sq.push_back(exp_al[1][0]);
            exp_sd = sq.pop_front();
            exp_ss = 1;
         end else if (sq.size() > 0) begin
            exp_sd = sq.pop_front();
            exp_ss = 0;
         end else begin
            exp_sd = 0;
            exp_ss = 0;
         end
         // report stage
         exp_rei_v = pf_v;
         if (pf_v) exp_rei = rei_en ? ((pf_e > RMAX) ? RMAX : pf_e) : 0;
         exp_rd_v = rd_req;
         begin
            int inc;
            int lens [2];
            int sets [2];
            int clrs [2];
            inc = pf_v ? pf_e : 0;
            if (rd_req) begin
               exp_rd = m_cnt;
               m_cnt = (inc > CMAX) ? CMAX : inc;
            end else begin
               m_cnt = (m_cnt + inc > CMAX) ? CMAX : m_cnt + inc;
            end
            lens[0] = exc_win; sets[0] = exc_set; clrs[0] = exc_clr;
            lens[1] = deg_win; sets[1] = deg_set; clrs[1] = deg_clr;
            if (pf_v) begin
               for (int a = 0; a < 2; a++) begin
                  int len, tot;
                  len = (lens[a] == 0) ? 1 : lens[a];
                  tot = m_sum[a] + pf_e;
                  if (tot > SMAX) tot = SMAX;
                  if (m_fc[a] + 1 >= len) begin
                     if (tot > sets[a]) exp_al[a] = 1;
                     else if (tot < clrs[a]) exp_al[a] = 0;
                     m_sum[a] = 0; m_fc[a] = 0;
                  end else begin
                     m_sum[a] = tot; m_fc[a]++;
                  end
               end
            end
         end
         // byte intake stage
         pf_v = 0;
         if (in_valid) begin
            int lane;
            lane = frame_start ? 0 : m_pos;
            if (frame_start) begin
               pf_v = m_refok;
               pf_e = m_ferr;
               if (m_seen) for (int i = 0; i < N; i++) m_ref[i] = m_acc[i];
               m_refok = m_seen;
               m_seen = 1;
               for (int i = 0; i < N; i++) m_acc[i] = 0;
               m_idx = 0;
               m_ferr = 0;
            end else if (b2_mark) begin
               if (m_refok && m_idx < N)
                  m_ferr += $countones(in_byte ^ 8'(m_ref[m_idx]));
               if (m_idx < N) m_idx++;
            end
            if (!rsoh) m_acc[lane] ^= int'(in_byte);
            m_pos = (lane + 1) % N;
         end
      end
   end

   // compared every clock, away from the rising edge
   always @(negedge clk) begin
      if (cmp_on) begin
         check("R2 R3 rei_valid", int'(rei_valid), exp_rei_v);
         check("R1 R4 R10 rei_value", int'(rei_value), exp_rei);
         check("R6 rd_valid", int'(rd_valid), exp_rd_v);
         check("R5 R6 rd_data", int'(rd_data), exp_rd);
         check("R7 exc_alarm", int'(exc_alarm), exp_al[0]);
         check("R8 deg_alarm", int'(deg_alarm), exp_al[1]);
         check("R9 ser_data", int'(ser_data), exp_sd);
         check("R9 ser_sync", int'(ser_sync), exp_ss);
      end
   end

   task automatic drive(input bit v, input logic [7:0] d, input bit fs,
                        input bit rs, input bit b2, input bit rd);
      in_valid = v; in_byte = d; frame_start = fs; rsoh = rs; b2_mark = b2; rd_req = rd;
      @(negedge clk);
   endtask

   // 24-byte frame: 4 overhead-row bytes, 4 parity bytes, payload
   task automatic send_frame(input logic [31:0] emask, input int gaps, input int rd_at);
      logic [7:0] d;
      for (int p = 0; p < FLEN; p++) begin
         if (gaps > 0 && (p % 7) == 3)
            for (int k = 0; k < gaps; k++) drive(1'b0, 8'($urandom), 1'b1, 1'b0, 1'b1, 1'b0);
         if (p < 4) begin
            drive(1'b1, 8'($urandom), p == 0, 1'b1, 1'b0, p == rd_at);
         end else if (p < 4 + N) begin
            d = 8'(m_ref[p-4]) ^ emask[8*(p-4) +: 8];
            drive(1'b1, d, 1'b0, 1'b0, 1'b1, p == rd_at);
         end else begin
            drive(1'b1, 8'($urandom), 1'b0, 1'b0, 1'b0, p == rd_at);
         end
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: outputs cleared in reset
      check("R11 rei_valid", int'(rei_valid), 0);
      check("R11 rei_value", int'(rei_value), 0);
      check("R11 rd_valid", int'(rd_valid), 0);
      check("R11 rd_data", int'(rd_data), 0);
      check("R11 alarms", int'(exc_alarm) + int'(deg_alarm), 0);
      check("R11 serial", int'(ser_data) + int'(ser_sync), 0);
      rst_n = 1'b1;
      cmp_on = 1;
      @(negedge clk);
      send_frame(32'h0, 0, -1);
      send_frame(32'h0, 0, -1);
      send_frame(32'h0000_0001, 0, -1);
      send_frame(32'h0000_00FF, 0, 10);
      send_frame(32'hFFFF_FFFF, 0, -1);
      send_frame(32'hFFFF_FFFF, 2, -1);
      send_frame(32'h0000_0007, 0, -1);
      rei_en = 1'b0;
      send_frame(32'h0001_0100, 0, -1);
      rei_en = 1'b1;
      send_frame(32'h0, 0, 5);
      send_frame(32'h0300_0000, 1, -1);
      send_frame(32'h0, 0, -1);
      send_frame(32'h0, 3, 2);
      send_frame(32'h0, 0, -1);
      send_frame(32'h0, 0, -1);
      repeat (20) drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
      summary();
      $finish;
   end

endmodule